// File: doc/BRIEF.md
# Single-Cycle Nine-Instruction 32-bit Processor

This block is a 32-bit processor core. It completes one instruction per clock cycle. Its instruction set is small: five register-to-register operations (add, sub, and, or, set-on-less-than), one word load, one word store, branch-on-equal and an unconditional jump. Program memory is a read-only word array whose contents come from a parameter. Data memory is a word array that reset loads from a second parameter. A 32-entry register file has a hard-wired zero register. The ALU raises a Zero flag, and the branch decision is taken from that flag.

The core has no data interface at its edge. Its only outputs are plain debug pins. They show the current program counter and the register-file write that will commit on the next rising edge. An integrator fixes the program and the initial data at elaboration, asserts reset, and then observes execution through these pins. All state changes on the rising clock edge.

Top module: `mini_cpu`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, clears every register to 0 and loads data memory word i from bits [32*i+31:32*i] of the data initial-contents parameter.
- R2: An instruction that is neither a taken branch nor a jump advances the PC by 4. The instruction word is taken from program word PC[7:2] for the default 64-word depth.
- R3: Opcode 000000 with shamt (bits 10:6) equal to 0 and funct (bits 5:0) equal to 100000, 100010, 100100 or 100101 writes rs+rt, rs-rt, rs AND rt or rs OR rt, in that order of codes, to the register named by bits 15:11. Here rs is bits 25:21 and rt is bits 20:16.
- R4: Funct 101010 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise.
- R5: Opcode 100011 (load) reads the data word at address rs + sign-extended bits 15:0, word index address[7:2], and writes it to the register named by bits 20:16.
- R6: Opcode 101011 (store) writes rt to the data word at rs + sign-extended bits 15:0 and performs no register write.
- R7: Opcode 000100 subtracts rt from rs. When the result is zero, the next PC is PC+4 plus the sign-extended bits 15:0 shifted left by two. Otherwise the next PC is PC+4.
- R8: Opcode 000010 sets the next PC to PC+4 bits 31:28, then bits 25:0 of the instruction, then two zero bits.
- R9: Register 0 always reads as 0. A write aimed at it is presented on the debug pins but leaves its value unchanged.
- R10: Any other opcode, any other funct, or a non-zero shamt acts as a no-op: no register write, no memory write, and the PC advances by 4.
- R11: dbg_pc equals the PC. dbg_rf_we, dbg_rf_addr and dbg_rf_data show, during the cycle, the register write of the instruction being executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dbg_pc | output | 32 | Current program counter |
| dbg_rf_we | output | 1 | Register write requested by the current instruction |
| dbg_rf_addr | output | 5 | Destination register of that write |
| dbg_rf_data | output | 32 | Value to be written |

## Verification
Each instruction's register write, memory write and debug values are combinational in the cycle the PC points at it. The PC change and the register and memory updates become visible one rising edge later. The bench therefore samples on the falling edge, compares against an instruction-level model, and only then advances that model by one instruction, so model and design move in lock step with no extra latency. Memory effects are observed one or more cycles later, when loads read back stored words.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    mem_to_reg;
    logic    mem_we;
    logic    alu_imm;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/mc_decoder.sv
module mc_decoder
  import mc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] shamt,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        if (shamt == 5'd0) begin
          ctrl.dst_rd = 1'b1;
          ctrl.reg_we = 1'b1;
          case (funct)
            FN_ADD:  ctrl.alu_op = ALU_ADD;
            FN_SUB:  ctrl.alu_op = ALU_SUB;
            FN_AND:  ctrl.alu_op = ALU_AND;
            FN_OR:   ctrl.alu_op = ALU_OR;
            FN_SLT:  ctrl.alu_op = ALU_SLT;
            default: ctrl.reg_we = 1'b0;
          endcase
        end
      end
      OP_LW: begin
        ctrl.reg_we     = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.alu_imm    = 1'b1;
      end
      OP_SW: begin
        ctrl.mem_we  = 1'b1;
        ctrl.alu_imm = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_J: ctrl.jump = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int W = 32,
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // R3
  wr_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst) && $past(wa) != '0 && ra1 == $past(wa)) |-> rd1 == $past(wd));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && $past(wa) == '0 && ra2 == '0) |-> rd2 == '0);
endmodule

// File: rtl/mc_dmem.sv
module mc_dmem #(
  parameter int W = 32,
  parameter int DEPTH = 64,
  parameter logic [W*DEPTH-1:0] INIT = '0,
  localparam int DA = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DA-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[i*W +: W];
    end else if (we) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];

  // R6
  st_ld_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && !$past(rst) && addr == $past(addr)) |-> rd == $past(wd));
endmodule

// File: rtl/mini_cpu.sv
module mini_cpu
  import mc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter logic [32*IMEM_WORDS-1:0] IMEM_INIT = '0,
  parameter logic [32*DMEM_WORDS-1:0] DMEM_INIT = '0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] dbg_pc,
  output logic        dbg_rf_we,
  output logic [4:0]  dbg_rf_addr,
  output logic [31:0] dbg_rf_data
);
  localparam int IA = $clog2(IMEM_WORDS);
  localparam int DA = $clog2(DMEM_WORDS);

  logic [31:0] rom [IMEM_WORDS];
  for (genvar g = 0; g < IMEM_WORDS; g++) begin : g_rom
    assign rom[g] = IMEM_INIT[g*32 +: 32];
  end

  logic [31:0] pc, pc_next, pc_plus4, br_tgt, j_tgt, instr, imm;
  logic [31:0] rs_val, rt_val, alu_b, alu_y, mem_rd, wr_data;
  logic [4:0]  wr_addr;
  logic        zero;
  ctrl_t       ctrl;

  assign instr = rom[pc[IA+1:2]];
  assign imm   = {{16{instr[15]}}, instr[15:0]};

  mc_decoder u_dec (
    .opcode(instr[31:26]), .shamt(instr[10:6]), .funct(instr[5:0]), .ctrl(ctrl)
  );

  mc_regfile #(.W(32), .N(32)) u_rf (
    .clk(clk), .rst(rst),
    .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rs_val), .rd2(rt_val),
    .we(ctrl.reg_we), .wa(wr_addr), .wd(wr_data)
  );

  assign alu_b = ctrl.alu_imm ? imm : rt_val;

  mc_alu #(.W(32)) u_alu (
    .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(zero)
  );

  mc_dmem #(.W(32), .DEPTH(DMEM_WORDS), .INIT(DMEM_INIT)) u_dmem (
    .clk(clk), .rst(rst), .we(ctrl.mem_we), .addr(alu_y[DA+1:2]),
    .wd(rt_val), .rd(mem_rd)
  );

  assign wr_addr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign wr_data = ctrl.mem_to_reg ? mem_rd : alu_y;

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm[29:0], 2'b00};
  assign j_tgt    = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                 pc_next = j_tgt;
    else if (ctrl.branch && zero)  pc_next = br_tgt;
    else                           pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign dbg_pc      = pc;
  assign dbg_rf_we   = ctrl.reg_we;
  assign dbg_rf_addr = wr_addr;
  assign dbg_rf_data = wr_data;

  // R1
  rst_pc_chk: assert property (@(posedge clk) rst |=> pc == '0);

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !(ctrl.branch && rs_val == rt_val)) |=> pc == $past(pc) + 32'd4);

  // R7
  beq_take_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.branch && rs_val == rt_val) |=>
      pc == $past(pc) + 32'd4 + $past({{14{instr[15]}}, instr[15:0], 2'b00}));

  // R6
  sw_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.mem_we |-> !ctrl.reg_we);
endmodule

// File: tb/test_mini_cpu.sv
`timescale 1ns/1ps
module test_mini_cpu;
  localparam int DEPTH = 64;
  localparam int RUN_CYCLES = 150;

  function automatic logic [31:0] rt_op(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] it_op(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic logic [32*DEPTH-1:0] build_prog();
    logic [32*DEPTH-1:0] p;
    logic [31:0] s;
    logic [5:0] fns [5];
    int k, lbl;
    p = '0; k = 0; s = 32'h1234_5678;
    fns[0] = 6'b100000; fns[1] = 6'b100010; fns[2] = 6'b100100;
    fns[3] = 6'b100101; fns[4] = 6'b101010;
    for (int i = 0; i < 6; i++) begin p[k*32 +: 32] = it_op(6'b100011, 0, i+1, 4*i); k++; end
    for (int i = 0; i < 24; i++) begin
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      p[k*32 +: 32] = rt_op(int'(s[3:0]), int'(s[7:4]), int'(s[11:8]), fns[int'(s[20:16]) % 5]); k++;
    end
    p[k*32 +: 32] = rt_op(1, 2, 0, 6'b100000); k++;
    p[k*32 +: 32] = rt_op(0, 0, 7, 6'b100101); k++;
    p[k*32 +: 32] = rt_op(2, 1, 8, 6'b100010); k++;
    p[k*32 +: 32] = rt_op(2, 1, 9, 6'b101010); k++;
    p[k*32 +: 32] = rt_op(1, 2, 10, 6'b101010); k++;
    p[k*32 +: 32] = rt_op(4, 3, 11, 6'b101010); k++;
    p[k*32 +: 32] = it_op(6'b101011, 0, 6, 24); k++;
    p[k*32 +: 32] = it_op(6'b100011, 0, 12, 28); k++;
    p[k*32 +: 32] = it_op(6'b101011, 12, 8, -8); k++;
    p[k*32 +: 32] = it_op(6'b100011, 0, 13, 24); k++;
    p[k*32 +: 32] = it_op(6'b100011, 0, 14, 32); k++;
    p[k*32 +: 32] = rt_op(1, 1, 15, 6'b000001); k++;
    p[k*32 +: 32] = {6'b000000, 5'd1, 5'd1, 5'd15, 5'd3, 6'b100000}; k++;
    p[k*32 +: 32] = it_op(6'b001000, 1, 15, 7); k++;
    p[k*32 +: 32] = it_op(6'b000100, 1, 2, 5); k++;
    p[k*32 +: 32] = it_op(6'b000100, 13, 6, 2); k++;
    p[k*32 +: 32] = rt_op(1, 1, 15, 6'b100000); k++;
    p[k*32 +: 32] = rt_op(1, 1, 15, 6'b100000); k++;
    lbl = k + 3;
    p[k*32 +: 32] = {6'b000010, 26'(lbl)}; k++;
    p[k*32 +: 32] = rt_op(1, 1, 16, 6'b100000); k++;
    p[k*32 +: 32] = {6'b000010, 26'(lbl + 1)}; k++;
    p[k*32 +: 32] = it_op(6'b000100, 0, 0, -3); k++;
    p[k*32 +: 32] = {6'b000010, 26'(k)}; k++;
    return p;
  endfunction

  function automatic logic [32*DEPTH-1:0] build_data();
    logic [32*DEPTH-1:0] d;
    d = '0;
    d[0*32 +: 32] = 32'd5;
    d[1*32 +: 32] = 32'hFFFF_FFFD;
    d[2*32 +: 32] = 32'h7FFF_FFFF;
    d[3*32 +: 32] = 32'h8000_0000;
    d[4*32 +: 32] = 32'h0F0F_00FF;
    d[5*32 +: 32] = 32'h1234_5678;
    d[7*32 +: 32] = 32'd40;
    return d;
  endfunction

  localparam logic [32*DEPTH-1:0] PROG = build_prog();
  localparam logic [32*DEPTH-1:0] DATA = build_data();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] dbg_pc, dbg_rf_data;
  logic        dbg_rf_we;
  logic [4:0]  dbg_rf_addr;

  always #10 clk = ~clk;

  mini_cpu #(.IMEM_WORDS(DEPTH), .DMEM_WORDS(DEPTH), .IMEM_INIT(PROG), .DMEM_INIT(DATA)) i_mini_cpu (
    .clk(clk), .rst(rst), .dbg_pc(dbg_pc),
    .dbg_rf_we(dbg_rf_we), .dbg_rf_addr(dbg_rf_addr), .dbg_rf_data(dbg_rf_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_pc;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at pc %h: actual %h expected %h", tag, what, m_pc, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [31:0] w);
    logic [5:0] op;
    op = w[31:26];
    if (op == 6'b000000 && w[10:6] == 5'd0 &&
        (w[5:0] == 6'b100000 || w[5:0] == 6'b100010 || w[5:0] == 6'b100100 || w[5:0] == 6'b100101))
      return (w[15:11] == 5'd0) ? "R9" : "R3";
    if (op == 6'b000000 && w[10:6] == 5'd0 && w[5:0] == 6'b101010) return "R4";
    if (op == 6'b100011) return "R5";
    if (op == 6'b101011) return "R6";
    if (op == 6'b000100) return "R7";
    if (op == 6'b000010) return "R8";
    return "R10";
  endfunction

  task automatic step_model();
    logic [31:0] w, a, b, sx, res, np;
    logic        we;
    logic [4:0]  wa;
    string       tg;
    w  = PROG[m_pc[7:2]*32 +: 32];
    tg = tag_of(w);
    a  = (w[25:21] == 0) ? 32'd0 : m_reg[w[25:21]];
    b  = (w[20:16] == 0) ? 32'd0 : m_reg[w[20:16]];
    sx = {{16{w[15]}}, w[15:0]};
    we = 1'b0; wa = 5'd0; res = 32'd0;
    np = m_pc + 32'd4;
    if (tg == "R3" || tg == "R4" || tg == "R9") begin
      we = 1'b1; wa = w[15:11];
      case (w[5:0])
        6'b100000: res = a + b;
        6'b100010: res = a - b;
        6'b100100: res = a & b;
        6'b100101: res = a | b;
        default:   res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      endcase
    end else if (tg == "R5") begin
      we = 1'b1; wa = w[20:16];
      res = m_mem[(a + sx) >> 2 & 32'h3F];
    end else if (tg == "R7") begin
      if (a == b) np = m_pc + 32'd4 + (sx << 2);
    end else if (tg == "R8") begin
      np = {np[31:28], w[25:0], 2'b00};
    end
    check({"R11/", tg}, "rf_we", {31'd0, dbg_rf_we}, {31'd0, we});
    if (we) begin
      check({"R11/", tg}, "rf_addr", {27'd0, dbg_rf_addr}, {27'd0, wa});
      check({"R11/", tg}, "rf_data", dbg_rf_data, res);
    end
    if (we && wa != 0) m_reg[wa] = res;
    if (tg == "R6") m_mem[(a + sx) >> 2 & 32'h3F] = b;
    m_pc = np;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = DATA[i*32 +: 32];
    m_pc = 32'd0;
    repeat (3) @(negedge clk);
    // R1: reset state of PC
    check("R1", "pc", dbg_pc, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < RUN_CYCLES; c++) begin
      // R2, R7, R8: the PC follows the model each cycle
      check((c == 0) ? "R1" : "R2", "pc", dbg_pc, m_pc);
      step_model();
      @(negedge clk);
    end
    // R1: a second reset mid-run returns the PC to 0
    rst = 1'b1;
    @(negedge clk);
    check("R1", "pc after re-reset", dbg_pc, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", "pc after release", dbg_pc, 32'd4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule